// File: doc/BRIEF.md
# Stack Pointer Change History Table

This block takes the place of the stack pointer field that each reorder buffer entry would otherwise carry. Most instructions leave the stack pointer alone. A record is written only when the instruction in an entry adjusts the stack pointer. The record holds the reorder buffer index of that entry and the stack pointer value it produces. A separate base register holds the committed stack pointer.

The lookup is combinational. Any reorder buffer index can be presented, and the table returns the stack pointer in effect for that entry. This is the value of the youngest record at or older than that index, or the base value when no such record exists. Recovery logic uses this result to restore the stack pointer after a mis-speculation.

Age is measured as the distance from the current buffer head, modulo the index range, so indices that have wrapped are still ordered correctly. When a record retires, its value moves into the base register. A flush removes every record from the flush point onward in one cycle. When all slots are in use, a stall output holds back decode of further stack-adjusting instructions.

Top module: `sp_hist_table`

## Requirements
- R1: After reset, no record is held, `base_sp_o` equals the parameter `RST_SP` (default 0x8000), `stall_o` is low, and every query returns `RST_SP`.
- R2: An insert (`ins_vld_i` high with no flush) stores the pair (`ins_idx_i`, `ins_sp_i`) at the next clock edge. A query of that same index then returns `ins_sp_i`.
- R3: A query of an index that has no record returns the value of the youngest record whose age is below the query's age.
- R4: A query whose index is older than every held record returns `base_sp_o`.
- R5: The age of index x is (x - `head_i`) mod 16. All ordering uses this age, so a record at index 1 is younger than one at index 14 when the head is 12.
- R6: On a retire (`ret_vld_i` with `ret_idx_i`), if a record exists at that index, the base register takes its value and the record is removed. If no record exists at that index, the base register keeps its value.
- R7: A flush (`flush_vld_i`, `flush_idx_i`) removes, at the next edge, every record whose age is at or above the age of `flush_idx_i`. Older records are kept.
- R8: `stall_o` is high exactly when all 8 slots hold records. An insert made while the table is full is dropped.
- R9: An insert in the same cycle as a flush is dropped.
- R10: An insert and a retire in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| head_i | input | 4 | Index of the oldest reorder buffer entry |
| ins_vld_i | input | 1 | Record a stack pointer change |
| ins_idx_i | input | 4 | Buffer index of the changing entry |
| ins_sp_i | input | 16 | Stack pointer produced by that entry |
| ret_vld_i | input | 1 | An entry retires |
| ret_idx_i | input | 4 | Index of the retiring entry |
| flush_vld_i | input | 1 | Flush request |
| flush_idx_i | input | 4 | Oldest flushed index |
| qry_idx_i | input | 4 | Index to look up |
| qry_sp_o | output | 16 | Stack pointer in effect for `qry_idx_i` |
| base_sp_o | output | 16 | Committed stack pointer |
| stall_o | output | 1 | Table full; hold stack-adjusting decode |

## Verification
An insert can arrive in the same cycle as either a flush or a retire, and these are the two collisions that matter. The bench drives an insert together with a flush from a mid-window index, and separately an insert together with the retire of a recorded head entry. After each, it sweeps every query index. Each result is compared with a model indexed by buffer position, which drops the insert under a flush and applies both changes under a retire.

// File: rtl/sp_hist_pkg.sv
package sp_hist_pkg;
  localparam int unsigned IDX_W = 4;
  localparam int unsigned SP_W  = 16;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic [SP_W-1:0]  sp;
  } sp_rec_t;
endpackage

// File: rtl/sp_hist_age.sv
module sp_hist_age #(
  parameter int unsigned IDX_W = 4
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [IDX_W-1:0] head_i,
  output logic [IDX_W-1:0] age_o
);
  // modular distance from the oldest entry
  assign age_o = idx_i - head_i;
endmodule

// File: rtl/sp_hist_alloc.sv
module sp_hist_alloc #(
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0]  vld_i,
  output logic              free_o,
  output logic [SLOT_W-1:0] slot_o
);
  always_comb begin
    free_o = ~&vld_i;
    slot_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld_i[i]) slot_o = SLOT_W'(i);
    end
  end
endmodule

// File: rtl/sp_hist_pick.sv
module sp_hist_pick #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AGE_W = 4,
  parameter int unsigned SP_W  = 16
) (
  input  logic [DEPTH-1:0] vld_i,
  input  logic [AGE_W-1:0] age_i [DEPTH],
  input  logic [SP_W-1:0]  sp_i  [DEPTH],
  input  logic [AGE_W-1:0] qage_i,
  input  logic [SP_W-1:0]  base_i,
  output logic [SP_W-1:0]  sp_o
);
  logic             hit;
  logic [AGE_W-1:0] best;

  // youngest record not younger than the query
  always_comb begin
    sp_o = base_i;
    hit  = 1'b0;
    best = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_i[i] && age_i[i] <= qage_i && (!hit || age_i[i] > best)) begin
        hit  = 1'b1;
        best = age_i[i];
        sp_o = sp_i[i];
      end
    end
  end
endmodule

// File: rtl/sp_hist_table.sv
module sp_hist_table
  import sp_hist_pkg::*;
#(
  parameter int unsigned    DEPTH  = 8,
  parameter logic [SP_W-1:0] RST_SP = 16'h8000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] head_i,
  input  logic             ins_vld_i,
  input  logic [IDX_W-1:0] ins_idx_i,
  input  logic [SP_W-1:0]  ins_sp_i,
  input  logic             ret_vld_i,
  input  logic [IDX_W-1:0] ret_idx_i,
  input  logic             flush_vld_i,
  input  logic [IDX_W-1:0] flush_idx_i,
  input  logic [IDX_W-1:0] qry_idx_i,
  output logic [SP_W-1:0]  qry_sp_o,
  output logic [SP_W-1:0]  base_sp_o,
  output logic             stall_o
);
  localparam int unsigned SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  vld_q;
  sp_rec_t           rec_q   [DEPTH];
  logic [SP_W-1:0]   base_q;
  logic [IDX_W-1:0]  rec_age [DEPTH];
  logic [SP_W-1:0]   rec_sp  [DEPTH];
  logic [IDX_W-1:0]  qry_age, flu_age;
  logic              free;
  logic [SLOT_W-1:0] slot;
  logic              do_ins;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    sp_hist_age #(.IDX_W(IDX_W)) u_age (
      .idx_i (rec_q[g].idx),
      .head_i(head_i),
      .age_o (rec_age[g])
    );
    assign rec_sp[g] = rec_q[g].sp;
  end

  sp_hist_age #(.IDX_W(IDX_W)) u_qry_age (
    .idx_i(qry_idx_i), .head_i(head_i), .age_o(qry_age)
  );

  sp_hist_age #(.IDX_W(IDX_W)) u_flu_age (
    .idx_i(flush_idx_i), .head_i(head_i), .age_o(flu_age)
  );

  sp_hist_alloc #(.DEPTH(DEPTH)) u_alloc (
    .vld_i (vld_q),
    .free_o(free),
    .slot_o(slot)
  );

  sp_hist_pick #(.DEPTH(DEPTH), .AGE_W(IDX_W), .SP_W(SP_W)) u_pick (
    .vld_i (vld_q),
    .age_i (rec_age),
    .sp_i  (rec_sp),
    .qage_i(qry_age),
    .base_i(base_q),
    .sp_o  (qry_sp_o)
  );

  // a flush always removes the entry being decoded
  assign do_ins = ins_vld_i && !flush_vld_i && free;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      base_q <= RST_SP;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ret_vld_i && vld_q[i] && rec_q[i].idx == ret_idx_i) begin
          vld_q[i] <= 1'b0;
          base_q   <= rec_q[i].sp;
        end
        if (flush_vld_i && vld_q[i] && rec_age[i] >= flu_age) vld_q[i] <= 1'b0;
      end
      if (do_ins) vld_q[slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_ins) rec_q[slot] <= '{idx: ins_idx_i, sp: ins_sp_i};
  end

  assign base_sp_o = base_q;
  assign stall_o   = &vld_q;
endmodule

// File: rtl/sp_hist_table_chk.sv
module sp_hist_table_chk #(
  parameter int unsigned DEPTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       head_i,
  input logic             ins_vld_i,
  input logic             ret_vld_i,
  input logic             flush_vld_i,
  input logic [3:0]       flush_idx_i,
  input logic [15:0]      qry_sp_o,
  input logic [15:0]      base_sp_o,
  input logic             stall_o,
  input logic [DEPTH-1:0] vld_q
);
  // R4
  empty_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q == '0 |-> qry_sp_o == base_sp_o);

  // R7
  flush_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_vld_i && flush_idx_i == head_i |=> vld_q == '0);

  // R6
  base_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ret_vld_i |=> $stable(base_sp_o));

  // R8
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_vld_i && stall_o && !ret_vld_i && !flush_vld_i |=> $stable(vld_q));

  // R2
  ins_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_vld_i && !stall_o && !ret_vld_i && !flush_vld_i
    |=> $countones(vld_q) == $countones($past(vld_q)) + 1);
endmodule

bind sp_hist_table sp_hist_table_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/sp_hist_table_tb.sv
module sp_hist_table_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] RST_SP = 16'h8000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  head_i = '0;
  logic        ins_vld_i = 1'b0;
  logic [3:0]  ins_idx_i = '0;
  logic [15:0] ins_sp_i = '0;
  logic        ret_vld_i = 1'b0;
  logic [3:0]  ret_idx_i = '0;
  logic        flush_vld_i = 1'b0;
  logic [3:0]  flush_idx_i = '0;
  logic [3:0]  qry_idx_i = '0;
  logic [15:0] qry_sp_o, base_sp_o;
  logic        stall_o;

  int n_chk = 0;
  int n_fail = 0;

  bit          m_has [16];
  logic [15:0] m_sp  [16];
  logic [15:0] m_base = RST_SP;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sp_hist_table u_dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int m_cnt();
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(m_has[i]);
    return c;
  endfunction

  function automatic logic [15:0] m_qry(logic [3:0] q);
    logic [3:0] a = q - head_i;
    for (int k = int'(a); k >= 0; k--) begin
      logic [3:0] ix = head_i + 4'(k);
      if (m_has[ix]) return m_sp[ix];
    end
    return m_base;
  endfunction

  task automatic op(bit ins, logic [3:0] iidx, logic [15:0] isp,
                    bit ret, bit flu, logic [3:0] fidx);
    int pre;
    @(negedge clk_i);
    ins_vld_i = ins; ins_idx_i = iidx; ins_sp_i = isp;
    ret_vld_i = ret; ret_idx_i = head_i;
    flush_vld_i = flu; flush_idx_i = fidx;
    pre = m_cnt();
    if (ret && m_has[head_i]) begin
      m_base = m_sp[head_i];
      m_has[head_i] = 1'b0;
    end
    if (flu) begin
      for (int i = 0; i < 16; i++)
        if (4'(i) - head_i >= fidx - head_i) m_has[i] = 1'b0;
    end
    if (ins && !flu && pre < 8) begin
      m_has[iidx] = 1'b1;
      m_sp[iidx] = isp;
    end
    @(negedge clk_i);
    ins_vld_i = 1'b0; ret_vld_i = 1'b0; flush_vld_i = 1'b0;
    if (ret) head_i = head_i + 4'd1;
  endtask

  task automatic ins(logic [3:0] idx, logic [15:0] sp);
    op(1'b1, idx, sp, 1'b0, 1'b0, 4'd0);
  endtask

  task automatic sweep(string tag);
    for (int q = 0; q < 16; q++) begin
      @(negedge clk_i);
      qry_idx_i = 4'(q);
      #1;
      chk(tag, 32'(qry_sp_o), 32'(m_qry(4'(q))));
    end
    chk({tag, " base"}, 32'(base_sp_o), 32'(m_base));
    chk({tag, " stall"}, 32'(stall_o), 32'(m_cnt() == 8));
  endtask

  task automatic clear_all();
    op(1'b0, 4'd0, 16'd0, 1'b0, 1'b1, head_i);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_has[i] = 1'b0; m_sp[i] = '0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state, R4 empty table
    sweep("R1 reset");

    // R2 R3 R4 basic lookup
    ins(4'd2, 16'd100);
    ins(4'd5, 16'd200);
    sweep("R2 R3 R4 lookup");

    // R5 wrapped ordering
    clear_all();
    head_i = 4'd12;
    ins(4'd14, 16'd300);
    ins(4'd1, 16'd400);
    sweep("R5 wrap");

    // R6 retire without and with a record
    op(1'b0, 4'd0, 16'd0, 1'b1, 1'b0, 4'd0);
    chk("R6 no record", 32'(base_sp_o), 32'(RST_SP));
    op(1'b0, 4'd0, 16'd0, 1'b1, 1'b0, 4'd0);
    op(1'b0, 4'd0, 16'd0, 1'b1, 1'b0, 4'd0);
    chk("R6 record", 32'(base_sp_o), 32'd300);
    sweep("R6 retire");

    // R8 fill and overflow
    clear_all();
    head_i = 4'd0;
    for (int i = 0; i < 8; i++) ins(4'(i), 16'(1000 + i));
    chk("R8 full", 32'(stall_o), 32'd1);
    ins(4'd8, 16'd9999);
    sweep("R8 dropped");

    // R7 partial flush
    op(1'b0, 4'd0, 16'd0, 1'b0, 1'b1, 4'd5);
    sweep("R7 flush");

    // R9 insert with flush
    op(1'b1, 4'd6, 16'd555, 1'b0, 1'b1, 4'd3);
    sweep("R9 ins+flush");

    // R10 insert with retire
    op(1'b1, 4'd9, 16'd77, 1'b1, 1'b0, 4'd0);
    chk("R10 base", 32'(base_sp_o), 32'd1000);
    sweep("R10 ins+ret");

    // R5 R3 every head position
    for (int h = 0; h < 16; h++) begin
      clear_all();
      head_i = 4'(h);
      ins(4'(h + 1), 16'(h * 16 + 1));
      ins(4'(h + 3), 16'(h * 16 + 3));
      ins(4'(h + 6), 16'(h * 16 + 6));
      sweep("R5 R3 head sweep");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule